// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block turns single-word host requests into the strobe sequences for a 36-bit-wide fast page mode DRAM array. The array uses multiplexed addressing. A request carries a 22-bit word address, a read/write flag, 36 bits of write data and four lane enables. The controller splits the address into a row half and a column half and drives both on one 11-bit address bus. It opens the row with the row strobes. It then performs column accesses while the row stays open, and it closes the row on a row miss, on a bus request from an outside agent, or before the longest allowed row-active time runs out. Read words come back on a one-cycle valid strobe, in the order the requests were accepted.

All writes are early writes. The write strobe falls one cycle before the column strobe, and the data pins are driven only while a write column strobe is low, so the bus never changes direction inside an access. Each of the four column strobes gates one 9-bit lane (eight data bits plus parity). Every limit is a parameter counted in cycles of a 100 MHz clock. The defaults are 3 cycles row-to-column delay, 2 cycles column strobe low, 4 cycles row precharge, and a row-active limit of 20000 cycles.

Refresh and power-up sequencing live in other blocks. They ask for the pins through `bus_req` and `bus_gnt`. The states are ST_IDLE (row closed), ST_ROW (row strobes low, row address out), ST_COLSET (column address, write strobe and lane choice set up), ST_STROBE (column strobes low), ST_OPEN (row open, column strobes high), ST_PRECH (row strobes high) and ST_GRANT (pins handed to the outside agent). The transitions are:
- ST_IDLE to ST_GRANT when a bus request is pending.
- ST_IDLE to ST_ROW when a host request is accepted.
- ST_ROW to ST_COLSET after the row-to-column delay.
- ST_COLSET to ST_STROBE after one cycle.
- ST_STROBE to ST_OPEN after the strobe width.
- ST_OPEN to ST_COLSET on a page hit.
- ST_OPEN to ST_PRECH on a miss, a bus request or timer expiry.
- ST_PRECH to ST_IDLE after the precharge time.
- ST_GRANT to ST_PRECH when the bus request drops.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: While reset is held and just after it, both row strobes, all column strobes and the write strobe are high, the data pins are not driven, and `rd_valid` and `bus_gnt` are low.
- R2: Address bits [21:11] are on `mem_a` in the cycle the row strobes fall. Bits [10:0] are on `mem_a` in the cycle the column strobes fall.
- R3: The first column strobe of an opened row falls exactly T_RCD+1 cycles after the row strobes fall. Column strobes are low only while both row strobes are low.
- R4: Column strobes stay low for exactly T_CAS cycles and are high for at least one cycle between accesses.
- R5: On a write, `mem_we_n` is low in the cycle before the column strobes fall and stays low, unchanged, while they are low. On a read it stays high.
- R6: Column strobe i covers data bits 9i to 9i+8. A write pulls low only the strobes whose `req_lanes` bit is 1, so the other lanes keep their old contents. A read pulls all four low.
- R7: The word present on `mem_dq_i` in the last strobe-low cycle of a read is returned on `rd_data` with `rd_valid` high for one cycle. That cycle is the first cycle with the column strobes high again. Results come back in request order.
- R8: A request whose row equals the open row is accepted without the row strobes rising. Back-to-back hits place column strobe falls 4 cycles apart.
- R9: After a row miss, the row strobes stay high for T_RP+1 cycles before the new row opens. They never fall after fewer than T_RP high cycles.
- R10: The row strobes are never low for more than T_RAS_MAX consecutive cycles. An open row with no further request closes by itself.
- R11: A pending `bus_req` wins over a host request in the same cycle. `bus_gnt` is given only once the row is closed and precharged, and while it is high all strobes are high, the data pins are released and `req_ready` is low.
- R12: `mem_dq_oe` is high only while a write holds its column strobes low, and `mem_dq_o` then carries the request's lane data.
- R13: Each row activation keeps the row strobes low for at least T_RCD+T_CAS+2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_addr | input | 22 | Word address, row in [21:11], column in [10:0] |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 36 | Write word, lane i in bits 9i..9i+8 |
| req_lanes | input | 4 | Lane enables for writes |
| rd_valid | output | 1 | Read word valid |
| rd_data | output | 36 | Read word |
| bus_req | input | 1 | Outside agent (refresh or init) wants the pins |
| bus_gnt | output | 1 | Pins handed to the outside agent |
| mem_a | output | 11 | Multiplexed row/column address |
| mem_ras_n | output | 2 | Row strobes, [0] lower half, [1] upper half |
| mem_cas_n | output | 4 | Column strobes, one per 9-bit lane |
| mem_we_n | output | 1 | Write strobe |
| mem_dq_o | output | 36 | Value for the data pads |
| mem_dq_oe | output | 1 | Data pad drive enable |
| mem_dq_i | input | 36 | Value seen on the data pads |

## Verification
Two things can land in the same cycle: a host request and an outside bus request, both arriving while a row is open. The bench raises `bus_req` and `req_valid` on the same falling edge. It then judges the outcome at the pins. The grant must come with all strobes high, `req_ready` must stay low and no read may return while the grant is held. After the grant is released, the held request must complete with the word the scoreboard expects.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ROW    = 3'd1,
        ST_COLSET = 3'd2,
        ST_STROBE = 3'd3,
        ST_OPEN   = 3'd4,
        ST_PRECH  = 3'd5,
        ST_GRANT  = 3'd6
    } fpm_state_e;

endpackage

// File: rtl/fpm_wait_cnt.sv
// Down counter that measures how long a timed state lasts.
module fpm_wait_cnt #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/fpm_page_timer.sv
// Counts cycles with the row strobes low and flags when another
// column access would no longer fit inside the row-active limit.
module fpm_page_timer #(
    parameter int T_RAS_MAX = 20000,
    parameter int ACC_CYC   = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic row_low,
    output logic expired
);

    localparam int CW = $clog2(T_RAS_MAX + 1);
    localparam logic [CW-1:0] LIMIT = CW'(T_RAS_MAX - ACC_CYC);
    localparam logic [CW-1:0] TOP   = CW'(T_RAS_MAX);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!row_low) begin
            cnt_q <= '0;
        end else if (cnt_q != TOP) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = (cnt_q >= LIMIT);

endmodule

// File: rtl/fpm_dpath.sv
// Request holding registers, row compare, lane select and read capture.
module fpm_dpath #(
    parameter int ADDR_W = 22,
    parameter int ROW_W  = 11,
    parameter int DATA_W = 36,
    parameter int LANES  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    accept,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic                    req_write,
    input  logic [DATA_W-1:0]       req_wdata,
    input  logic [LANES-1:0]        req_lanes,
    input  logic                    capture,
    input  logic [DATA_W-1:0]       dq_in,
    output logic [ROW_W-1:0]        row_q,
    output logic [ADDR_W-ROW_W-1:0] col_q,
    output logic                    wr_q,
    output logic [DATA_W-1:0]       wdata_q,
    output logic [LANES-1:0]        lane_on,
    output logic                    row_hit,
    output logic                    rd_valid,
    output logic [DATA_W-1:0]       rd_data
);

    localparam int COL_W = ADDR_W - ROW_W;

    logic [LANES-1:0] lanes_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q   <= '0;
            col_q   <= '0;
            wr_q    <= 1'b0;
            wdata_q <= '0;
            lanes_q <= '0;
        end else if (accept) begin
            row_q   <= req_addr[ADDR_W-1 -: ROW_W];
            col_q   <= req_addr[COL_W-1:0];
            wr_q    <= req_write;
            wdata_q <= req_wdata;
            lanes_q <= req_lanes;
        end
    end

    assign row_hit = (req_addr[ADDR_W-1 -: ROW_W] == row_q);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_on[g] = wr_q ? lanes_q[g] : 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= capture;
            if (capture) begin
                rd_data <= dq_in;
            end
        end
    end

endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl
    import fpm_pkg::*;
#(
    parameter int ADDR_W    = 22,
    parameter int ROW_W     = 11,
    parameter int DATA_W    = 36,
    parameter int LANES     = 4,
    parameter int T_RCD     = 3,
    parameter int T_CAS     = 2,
    parameter int T_RP      = 4,
    parameter int T_RAS_MAX = 20000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_lanes,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    input  logic              bus_req,
    output logic              bus_gnt,
    output logic [ROW_W-1:0]  mem_a,
    output logic [1:0]        mem_ras_n,
    output logic [LANES-1:0]  mem_cas_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);

    localparam int COL_W   = ADDR_W - ROW_W;
    localparam int ACC_CYC = T_CAS + 3;
    localparam int T_MAX1  = (T_RCD > T_CAS) ? T_RCD : T_CAS;
    localparam int T_MAX2  = (T_MAX1 > T_RP) ? T_MAX1 : T_RP;
    localparam int WAIT_W  = $clog2(T_MAX2 + 1);

    fpm_state_e state_q, state_n;

    logic              wait_load, wait_done;
    logic [WAIT_W-1:0] wait_val;
    logic              row_low, expired, accept, capture;
    logic              row_hit, wr_q;
    logic [ROW_W-1:0]  row_q;
    logic [COL_W-1:0]  col_q;
    logic [DATA_W-1:0] wdata_q;
    logic [LANES-1:0]  lane_on;

    fpm_wait_cnt #(.W(WAIT_W)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wait_load),
        .load_val (wait_val),
        .done     (wait_done)
    );

    fpm_page_timer #(.T_RAS_MAX(T_RAS_MAX), .ACC_CYC(ACC_CYC)) u_page (
        .clk     (clk),
        .rst_n   (rst_n),
        .row_low (row_low),
        .expired (expired)
    );

    fpm_dpath #(
        .ADDR_W (ADDR_W),
        .ROW_W  (ROW_W),
        .DATA_W (DATA_W),
        .LANES  (LANES)
    ) u_dpath (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .req_addr  (req_addr),
        .req_write (req_write),
        .req_wdata (req_wdata),
        .req_lanes (req_lanes),
        .capture   (capture),
        .dq_in     (mem_dq_i),
        .row_q     (row_q),
        .col_q     (col_q),
        .wr_q      (wr_q),
        .wdata_q   (wdata_q),
        .lane_on   (lane_on),
        .row_hit   (row_hit),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    // acceptance: outside agent always wins
    always_comb begin
        req_ready = 1'b0;
        if (!bus_req) begin
            if (state_q == ST_IDLE) begin
                req_ready = 1'b1;
            end else if (state_q == ST_OPEN) begin
                req_ready = row_hit && !expired;
            end
        end
    end

    assign accept  = req_valid && req_ready;
    assign capture = (state_q == ST_STROBE) && wait_done && !wr_q;

    // next state
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (bus_req) begin
                    state_n = ST_GRANT;
                end else if (req_valid) begin
                    state_n = ST_ROW;
                end
            end
            ST_ROW: begin
                if (wait_done) begin
                    state_n = ST_COLSET;
                end
            end
            ST_COLSET: begin
                state_n = ST_STROBE;
            end
            ST_STROBE: begin
                if (wait_done) begin
                    state_n = ST_OPEN;
                end
            end
            ST_OPEN: begin
                if (bus_req || expired) begin
                    state_n = ST_PRECH;
                end else if (req_valid) begin
                    state_n = row_hit ? ST_COLSET : ST_PRECH;
                end
            end
            ST_PRECH: begin
                if (wait_done) begin
                    state_n = ST_IDLE;
                end
            end
            ST_GRANT: begin
                if (!bus_req) begin
                    state_n = ST_PRECH;
                end
            end
            default: begin
                state_n = ST_IDLE;
            end
        endcase
    end

    // timed-state lengths, loaded on each state change
    always_comb begin
        wait_load = (state_n != state_q);
        unique case (state_n)
            ST_ROW:    wait_val = WAIT_W'(T_RCD - 1);
            ST_STROBE: wait_val = WAIT_W'(T_CAS - 1);
            ST_PRECH:  wait_val = WAIT_W'(T_RP - 1);
            default:   wait_val = '0;
        endcase
    end

    // pin outputs
    always_comb begin
        mem_a     = '0;
        mem_ras_n = 2'b11;
        mem_cas_n = '1;
        mem_we_n  = 1'b1;
        mem_dq_oe = 1'b0;
        bus_gnt   = 1'b0;
        row_low   = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_PRECH: begin
            end
            ST_ROW: begin
                mem_a     = row_q;
                mem_ras_n = 2'b00;
                row_low   = 1'b1;
            end
            ST_COLSET: begin
                mem_a     = ROW_W'(col_q);
                mem_ras_n = 2'b00;
                mem_we_n  = !wr_q;
                row_low   = 1'b1;
            end
            ST_STROBE: begin
                mem_a     = ROW_W'(col_q);
                mem_ras_n = 2'b00;
                mem_cas_n = ~lane_on;
                mem_we_n  = !wr_q;
                mem_dq_oe = wr_q;
                row_low   = 1'b1;
            end
            ST_OPEN: begin
                mem_ras_n = 2'b00;
                row_low   = 1'b1;
            end
            ST_GRANT: begin
                bus_gnt = 1'b1;
            end
            default: begin
            end
        endcase
    end

    assign mem_dq_o = wdata_q;

endmodule

// File: rtl/fpm_dram_chk.sv
module fpm_dram_chk #(
    parameter int LANES     = 4,
    parameter int T_CAS     = 2,
    parameter int T_RP      = 4,
    parameter int T_RAS_MAX = 20000
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mem_ras_n,
    input logic [LANES-1:0] mem_cas_n,
    input logic             mem_we_n,
    input logic             mem_dq_oe,
    input logic             bus_gnt,
    input logic             rd_valid
);

    localparam int RW = $clog2(T_RAS_MAX + 2);

    logic          cas_idle;
    logic [RW-1:0] ras_lo;
    logic [7:0]    ras_hi;
    logic [7:0]    cas_lo;

    assign cas_idle = &mem_cas_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ras_lo <= '0;
            ras_hi <= 8'(T_RP);
            cas_lo <= '0;
        end else begin
            ras_lo <= mem_ras_n[0] ? '0 : ras_lo + 1'b1;
            ras_hi <= !mem_ras_n[0] ? 8'd0 : ((ras_hi == 8'hFF) ? ras_hi : ras_hi + 8'd1);
            cas_lo <= cas_idle ? 8'd0 : cas_lo + 8'd1;
        end
    end

    AST_CAS_INSIDE_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_idle |-> (mem_ras_n == 2'b00)); // R3

    AST_CAS_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cas_idle) |-> (cas_lo == 8'(T_CAS))); // R4

    AST_EARLY_WE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cas_idle) && !mem_we_n) |-> $past(!mem_we_n)); // R5

    AST_WE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cas_idle && !$past(cas_idle)) |-> $stable(mem_we_n)); // R5

    AST_BUS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (!mem_we_n && !cas_idle)); // R12

    AST_RAS_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ras_n[0] |-> (ras_lo < RW'(T_RAS_MAX))); // R10

    AST_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_ras_n[0]) |-> (ras_hi >= 8'(T_RP))); // R9

    AST_GRANT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        bus_gnt |-> (mem_ras_n == 2'b11 && cas_idle && mem_we_n && !mem_dq_oe)); // R11

    AST_RDV_AFTER_CAS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $rose(cas_idle)); // R7

endmodule

bind fpm_dram_ctrl fpm_dram_chk #(
    .LANES     (LANES),
    .T_CAS     (T_CAS),
    .T_RP      (T_RP),
    .T_RAS_MAX (T_RAS_MAX)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_ras_n (mem_ras_n),
    .mem_cas_n (mem_cas_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_oe (mem_dq_oe),
    .bus_gnt   (bus_gnt),
    .rd_valid  (rd_valid)
);

// File: tb/fpm_dram_ctrl_test.sv
module fpm_dram_ctrl_test;

    localparam int TRAS = 60;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [21:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [35:0] req_wdata = '0;
    logic [3:0]  req_lanes = '0;
    logic        rd_valid;
    logic [35:0] rd_data;
    logic        bus_req = 1'b0;
    logic        bus_gnt;
    logic [10:0] mem_a;
    logic [1:0]  mem_ras_n;
    logic [3:0]  mem_cas_n;
    logic        mem_we_n;
    logic [35:0] mem_dq_o;
    logic        mem_dq_oe;
    logic [35:0] mem_dq_i;

    always #5 clk = ~clk;

    fpm_dram_ctrl #(.T_RAS_MAX(TRAS)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_wdata(req_wdata), .req_lanes(req_lanes),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .bus_req(bus_req), .bus_gnt(bus_gnt),
        .mem_a(mem_a), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
        .mem_we_n(mem_we_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
        .mem_dq_i(mem_dq_i)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [35:0] seed_word(input logic [7:0] i);
        return {i, 1'b1, ~i, 1'b0, i, 1'b1, ~i, 1'b0};
    endfunction

    function automatic logic [7:0] idx(input logic [10:0] r, input logic [10:0] c);
        return {r[3:0], c[3:0]};
    endfunction

    // array model and bench reference copy
    logic [35:0] dram [256];
    logic [35:0] refm [256];
    logic [10:0] m_row = '0;

    assign mem_dq_i = (mem_we_n && mem_cas_n != 4'hF) ? dram[{m_row[3:0], mem_a[3:0]}] : 36'h0;

    // scoreboard
    logic [35:0] exp_q[$];
    logic [10:0] exp_row, exp_col;
    bit          exp_wr;
    logic [3:0]  exp_ln;
    logic [35:0] exp_d;

    task automatic send(input logic [10:0] r, input logic [10:0] c, input bit wr,
                        input logic [35:0] d, input logic [3:0] ln);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = {r, c};
        req_write = wr;
        req_wdata = d;
        req_lanes = ln;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        exp_row = r; exp_col = c; exp_wr = wr; exp_ln = ln; exp_d = d;
        if (wr) begin
            for (int k = 0; k < 4; k++)
                if (ln[k]) refm[idx(r, c)][9*k +: 9] = d[9*k +: 9];
        end else begin
            exp_q.push_back(refm[idx(r, c)]);
        end
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    // protocol monitor
    int  cyc = 0;
    bit  p_ras_lo = 0, p_cas_lo = 0, p_we_n = 1, first_cas = 0, had_rise = 0;
    int  ras_fall_cyc = 0, ras_rise_cyc = 0, cas_fall_cyc = 0;
    int  last_gap = 0, last_ras_hi = 0, max_ras_lo = 0, rise_cnt = 0, rdv_cnt = 0;
    bit  finished = 0;

    always @(negedge clk) begin
        bit ras_lo, cas_lo;
        cyc++;
        if (cyc == 150000 && !finished) begin
            chk(1'b0, "watchdog", 64'(cyc), 64'd0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
        if (rst_n) begin
            ras_lo = !mem_ras_n[0];
            cas_lo = (mem_cas_n != 4'hF);
            if (ras_lo && !p_ras_lo) begin
                chk(mem_a == exp_row, "R2 row addr", 64'(mem_a), 64'(exp_row));
                if (had_rise)
                    last_ras_hi = cyc - ras_rise_cyc;
                ras_fall_cyc = cyc;
                first_cas = 1;
                m_row = mem_a;
            end
            if (!ras_lo && p_ras_lo) begin
                int lo;
                lo = cyc - ras_fall_cyc;
                if (lo > max_ras_lo) max_ras_lo = lo;
                chk(lo >= 7, "R13 ras low width", 64'(lo), 64'd7);
                chk(lo <= TRAS, "R10 ras low limit", 64'(lo), 64'(TRAS));
                ras_rise_cyc = cyc;
                had_rise = 1;
                rise_cnt++;
            end
            if (cas_lo && !p_cas_lo) begin
                chk(mem_a == exp_col, "R2 col addr", 64'(mem_a), 64'(exp_col));
                chk(mem_cas_n == (exp_wr ? ~exp_ln : 4'h0), "R6 lane strobes",
                    64'(mem_cas_n), 64'(exp_wr ? ~exp_ln : 4'h0));
                chk(mem_we_n == !exp_wr && (!exp_wr || !p_we_n), "R5 early write",
                    64'({p_we_n, mem_we_n}), 64'({!exp_wr, !exp_wr}));
                if (first_cas)
                    chk(cyc - ras_fall_cyc == 4, "R3 ras to cas", 64'(cyc - ras_fall_cyc), 64'd4);
                else
                    last_gap = cyc - cas_fall_cyc;
                first_cas = 0;
                cas_fall_cyc = cyc;
                if (exp_wr) begin
                    chk(mem_dq_oe && mem_dq_o == exp_d, "R12 write drive",
                        64'(mem_dq_o), 64'(exp_d));
                    for (int k = 0; k < 4; k++)
                        if (!mem_cas_n[k]) dram[{m_row[3:0], mem_a[3:0]}][9*k +: 9] = mem_dq_o[9*k +: 9];
                end
            end
            if (!cas_lo && p_cas_lo)
                chk(cyc - cas_fall_cyc == 2, "R4 cas width", 64'(cyc - cas_fall_cyc), 64'd2);
            if (mem_dq_oe)
                chk(!mem_we_n && cas_lo, "R12 bus only in write", 64'({mem_we_n, cas_lo}), 64'b01);
            if (rd_valid) begin
                rdv_cnt++;
                chk(!cas_lo && p_cas_lo, "R7 valid timing", 64'({p_cas_lo, cas_lo}), 64'b10);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7 unexpected read", 64'(rd_data), 64'd0);
                end else begin
                    logic [35:0] e;
                    e = exp_q.pop_front();
                    chk(rd_data == e, "R7 read data", 64'(rd_data), 64'(e));
                end
            end
            p_ras_lo = ras_lo;
            p_cas_lo = cas_lo;
            p_we_n   = mem_we_n;
        end
    end

    task automatic drain();
        for (int k = 0; k < 200 && exp_q.size() != 0; k++) @(negedge clk);
    endtask

    initial begin
        int rc;
        for (int i = 0; i < 256; i++) begin
            dram[i] = seed_word(8'(i));
            refm[i] = seed_word(8'(i));
        end
        exp_row = '0; exp_col = '0; exp_wr = 0; exp_ln = '0; exp_d = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(mem_ras_n == 2'b11 && mem_cas_n == 4'hF && mem_we_n && !mem_dq_oe && !rd_valid && !bus_gnt,
            "R1 in reset", 64'({mem_ras_n, mem_cas_n, mem_we_n, mem_dq_oe, rd_valid, bus_gnt}), 64'h3F8);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_ras_n == 2'b11 && mem_cas_n == 4'hF && mem_we_n && !mem_dq_oe && !rd_valid && !bus_gnt,
            "R1 after reset", 64'({mem_ras_n, mem_cas_n, mem_we_n, mem_dq_oe, rd_valid, bus_gnt}), 64'h3F8);

        // write, read back
        send(11'd1, 11'd2, 1, 36'h1_2345_6789, 4'hF);
        send(11'd1, 11'd2, 0, '0, 4'h0);
        drain();

        // R8 page hits
        rc = rise_cnt;
        send(11'd1, 11'd3, 0, '0, 4'h0);
        send(11'd1, 11'd4, 0, '0, 4'h0);
        send(11'd1, 11'd5, 0, '0, 4'h0);
        drain();
        chk(last_gap == 4, "R8 page hit spacing", 64'(last_gap), 64'd4);
        chk(rise_cnt == rc, "R8 row stays open", 64'(rise_cnt), 64'(rc));

        // R6 partial write then read back
        send(11'd1, 11'd2, 1, 36'hA_BCDE_F012, 4'b0101);
        send(11'd1, 11'd2, 0, '0, 4'h0);
        drain();

        // R9 row miss
        send(11'd2, 11'd1, 0, '0, 4'h0);
        drain();
        chk(last_ras_hi == 5, "R9 miss precharge", 64'(last_ras_hi), 64'd5);

        // R10 idle row closes by itself
        repeat (100) @(negedge clk);
        chk(mem_ras_n == 2'b11, "R10 idle close", 64'(mem_ras_n), 64'h3);

        // R10 long stream of hits
        rc = rise_cnt;
        for (int k = 0; k < 20; k++) send(11'd3, 11'(k % 16), 0, '0, 4'h0);
        drain();
        chk(max_ras_lo <= TRAS, "R10 stream limit", 64'(max_ras_lo), 64'(TRAS));
        chk(rise_cnt > rc, "R10 stream reopens", 64'(rise_cnt), 64'(rc + 1));

        // R11 bus request against host request in the same cycle
        send(11'd4, 11'd5, 0, '0, 4'h0);
        fork
            begin
                int rv;
                @(negedge clk);
                bus_req = 1'b1;
                for (int k = 0; k < 30 && !bus_gnt; k++) @(negedge clk);
                chk(bus_gnt, "R11 grant given", 64'(bus_gnt), 64'd1);
                chk(mem_ras_n == 2'b11 && mem_cas_n == 4'hF, "R11 strobes idle",
                    64'({mem_ras_n, mem_cas_n}), 64'h3F);
                rv = rdv_cnt;
                repeat (8) @(negedge clk);
                chk(!req_ready && bus_gnt, "R11 host held off", 64'({req_ready, bus_gnt}), 64'b01);
                chk(rdv_cnt == rv, "R11 no access in grant", 64'(rdv_cnt), 64'(rv));
                bus_req = 1'b0;
            end
            begin
                send(11'd4, 11'd6, 0, '0, 4'h0);
            end
        join
        drain();

        // write after read on an open row, then read back
        send(11'd4, 11'd6, 1, 36'h5_5AA5_3CC3, 4'b1010);
        send(11'd4, 11'd6, 0, '0, 4'h0);
        drain();
        chk(exp_q.size() == 0, "R7 all reads returned", 64'(exp_q.size()), 64'd0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule